// File: doc/BRIEF.md
# Condition Register Compare Unit

This block keeps a 32-bit condition register split into eight 4-bit fields. Field 0 sits in the top nibble and field 7 in the bottom one. Three kinds of write reach it.

- **Compare.** A compare takes a first operand and either a second register operand or a 16-bit immediate. It orders them as signed or unsigned numbers. It then writes a field chosen by the caller, holding exactly one ordering flag and a copy of the summary overflow bit.
- **Arithmetic result update.** An ALU result can be compared against zero and written into field 0. This comparison is always signed. It uses the summary overflow as it stands after that same operation's overflow update.
- **Masked write.** A 32-bit general-register value can be copied in under an 8-bit field mask.

The whole register is always visible on a read port. Only one write source is accepted per clock, in a fixed priority. The new register value appears on the read port in the cycle after the edge that sampled the request.

Top module: `crf_cmp_unit`

## Requirements
- R1: While reset is low, and on the first clock after it, `cr_out` reads all zeros.
- R2: Field k occupies `cr_out` bits [31-4k : 28-4k]. Inside a field, the most significant bit is less-than, then greater-than, then equal, and the least significant bit is summary overflow.
- R3: With `cmp_signed`=1, the first operand and the second operand are ordered as 32-bit two's complement numbers.
- R4: With `cmp_signed`=0, the first operand and the second operand are ordered as 32-bit unsigned numbers.
- R5: With `cmp_use_imm`=1, the second operand is `cmp_imm`. It is sign-extended from bit 15 in signed mode and zero-extended in unsigned mode. `cmp_b` is then ignored.
- R6: A compare sets exactly one of less-than, greater-than and equal. It sets the field's summary overflow bit to `so_in`. It leaves the other seven fields unchanged.
- R7: A result update writes field 0 from a signed compare of `res_value` with zero. Its summary overflow bit is `so_in | (res_ov_valid & res_ov)`.
- R8: In a masked write, mask bit 7-k set copies `mw_data` bits [31-4k : 28-4k] into field k. A clear mask bit leaves field k unchanged, so a mask of 8'hFF writes the whole register and 8'h00 writes nothing.
- R9: When several requests arrive in one cycle, a compare beats a result update, which beats a masked write. The losing requests have no effect.
- R10: An accepted write is visible on `cr_out` one clock after the sampling edge. With no request, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request |
| cmp_field | input | 3 | Destination field of the compare |
| cmp_signed | input | 1 | 1 = signed ordering, 0 = unsigned |
| cmp_use_imm | input | 1 | 1 = second operand taken from the immediate |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand (register form) |
| cmp_imm | input | 16 | Immediate second operand |
| so_in | input | 1 | Current summary overflow from the exception register |
| res_valid | input | 1 | Arithmetic result update request |
| res_value | input | 32 | ALU result to compare with zero |
| res_ov_valid | input | 1 | The same operation also updates overflow |
| res_ov | input | 1 | Overflow produced by that operation |
| mw_valid | input | 1 | Masked write request |
| mw_mask | input | 8 | Field mask; bit 7 selects field 0 |
| mw_data | input | 32 | Source value for the masked write |
| cr_out | output | 32 | Whole condition register |

## Verification
Every write is combinational up to a single register stage. A request driven before edge N therefore shows its effect on `cr_out` after edge N and no earlier. The bench drives inputs on the falling edge and advances its behavioural register model at the same time. It compares against the design on the next falling edge, after exactly one rising edge has passed. Requests that should be ignored are checked the same way: the model leaves the untouched fields alone, and the full 32-bit comparison one cycle later shows they held.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_flags_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CMP  = 2'd1,
    SRC_RES  = 2'd2,
    SRC_MW   = 2'd3
  } crf_src_e;
endpackage

// File: rtl/crf_compare.sv
module crf_compare
  import crf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              is_signed,
  input  logic              so,
  output crf_flags_t        flags
);
  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] extend_imm(input logic [IMM_W-1:0] v, input logic sgn);
    logic fill;
    fill = sgn & v[IMM_W-1];
    return {{EXT_W{fill}}, v};
  endfunction

  function automatic logic less_than(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                     input logic sgn);
    if (sgn) return $signed(x) < $signed(y);
    return x < y;
  endfunction

  logic [DATA_W-1:0] rhs;
  logic              is_lt, is_eq;

  always_comb begin
    rhs   = use_imm ? extend_imm(imm, is_signed) : op_b;
    is_lt = less_than(op_a, rhs, is_signed);
    is_eq = (op_a == rhs);
    flags.lt = is_lt;
    flags.gt = ~is_lt & ~is_eq;
    flags.eq = is_eq;
    flags.so = so;
  end
endmodule

// File: rtl/crf_field_merge.sv
module crf_field_merge #(
  parameter int NFIELD  = 8,
  parameter int FIELD_W = 4
) (
  input  logic [NFIELD*FIELD_W-1:0] cur,
  input  logic [NFIELD-1:0]         wr_en,
  input  logic [NFIELD*FIELD_W-1:0] new_data,
  output logic [NFIELD*FIELD_W-1:0] nxt
);
  for (genvar k = 0; k < NFIELD; k++) begin : g_field
    localparam int LO = (NFIELD - 1 - k) * FIELD_W;
    assign nxt[LO +: FIELD_W] = wr_en[k] ? new_data[LO +: FIELD_W] : cur[LO +: FIELD_W];
  end
endmodule

// File: rtl/crf_cmp_unit.sv
module crf_cmp_unit
  import crf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int NFIELD = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmp_valid,
  input  logic [$clog2(NFIELD)-1:0] cmp_field,
  input  logic                      cmp_signed,
  input  logic                      cmp_use_imm,
  input  logic [DATA_W-1:0]         cmp_a,
  input  logic [DATA_W-1:0]         cmp_b,
  input  logic [IMM_W-1:0]          cmp_imm,
  input  logic                      so_in,
  input  logic                      res_valid,
  input  logic [DATA_W-1:0]         res_value,
  input  logic                      res_ov_valid,
  input  logic                      res_ov,
  input  logic                      mw_valid,
  input  logic [NFIELD-1:0]         mw_mask,
  input  logic [NFIELD*FIELD_W-1:0] mw_data,
  output logic [NFIELD*FIELD_W-1:0] cr_out
);
  localparam int CR_W = NFIELD * FIELD_W;

  crf_flags_t        cmp_flags, res_flags;
  logic              res_so;
  crf_src_e          src;
  logic [NFIELD-1:0] wr_en;
  logic [CR_W-1:0]   new_data, cr_nxt, cr_q;

  crf_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
    .op_a(cmp_a), .op_b(cmp_b), .imm(cmp_imm), .use_imm(cmp_use_imm),
    .is_signed(cmp_signed), .so(so_in), .flags(cmp_flags)
  );

  assign res_so = so_in | (res_ov_valid & res_ov);

  crf_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_res (
    .op_a(res_value), .op_b('0), .imm('0), .use_imm(1'b0),
    .is_signed(1'b1), .so(res_so), .flags(res_flags)
  );

  always_comb begin
    if (cmp_valid)      src = SRC_CMP;
    else if (res_valid) src = SRC_RES;
    else if (mw_valid)  src = SRC_MW;
    else                src = SRC_NONE;
  end

  always_comb begin
    wr_en    = '0;
    new_data = '0;
    unique case (src)
      SRC_CMP: begin
        wr_en[cmp_field] = 1'b1;
        new_data = {NFIELD{cmp_flags}};
      end
      SRC_RES: begin
        wr_en[0] = 1'b1;
        new_data = {NFIELD{res_flags}};
      end
      SRC_MW: begin
        for (int k = 0; k < NFIELD; k++) wr_en[k] = mw_mask[NFIELD-1-k];
        new_data = mw_data;
      end
      default: ;
    endcase
  end

  crf_field_merge #(.NFIELD(NFIELD), .FIELD_W(FIELD_W)) u_merge (
    .cur(cr_q), .wr_en(wr_en), .new_data(new_data), .nxt(cr_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_nxt;
  end

  assign cr_out = cr_q;
endmodule

// File: rtl/crf_cmp_unit_chk.sv
module crf_cmp_unit_chk #(
  parameter int NFIELD  = 8,
  parameter int FIELD_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmp_valid,
  input logic                      res_valid,
  input logic                      mw_valid,
  input logic [NFIELD-1:0]         mw_mask,
  input logic [$clog2(NFIELD)-1:0] cmp_field,
  input logic                      so_in,
  input logic                      res_ov_valid,
  input logic                      res_ov,
  input logic [FIELD_W-1:0]        cmp_nib,
  input logic [NFIELD-1:0]         wr_en,
  input logic [NFIELD*FIELD_W-1:0] cr_out
);
  logic                      p_cmp, p_res, p_so, p_res_so;
  logic [$clog2(NFIELD)-1:0] p_field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_cmp <= 1'b0; p_res <= 1'b0; p_so <= 1'b0; p_res_so <= 1'b0; p_field <= '0;
    end else begin
      p_cmp    <= cmp_valid;
      p_res    <= res_valid & ~cmp_valid;
      p_so     <= so_in;
      p_res_so <= so_in | (res_ov_valid & res_ov);
      p_field  <= cmp_field;
    end
  end

  // R6
  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $countones(cmp_nib[FIELD_W-1:1]) == 1);
  // R6
  a_r6_one_field: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $onehot(wr_en));
  // R6
  a_r6_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
    p_cmp |-> cr_out[(NFIELD-1-p_field)*FIELD_W] == p_so);
  // R7
  a_r7_res_so: assert property (@(posedge clk) disable iff (!rst_n)
    p_res |-> cr_out[(NFIELD-1)*FIELD_W] == p_res_so);
  // R8
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !cmp_valid && !res_valid && mw_mask == '0) |=> $stable(cr_out));
  // R10
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !res_valid && !mw_valid) |=> $stable(cr_out));
endmodule

bind crf_cmp_unit crf_cmp_unit_chk #(.NFIELD(NFIELD), .FIELD_W(crf_pkg::FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .res_valid(res_valid),
  .mw_valid(mw_valid), .mw_mask(mw_mask), .cmp_field(cmp_field), .so_in(so_in),
  .res_ov_valid(res_ov_valid), .res_ov(res_ov), .cmp_nib(cmp_flags), .wr_en(wr_en),
  .cr_out(cr_out)
);

// File: tb/crf_cmp_unit_bench.sv
module crf_cmp_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid, cmp_signed, cmp_use_imm, so_in;
  logic [2:0]  cmp_field;
  logic [31:0] cmp_a, cmp_b, res_value, mw_data;
  logic [15:0] cmp_imm;
  logic        res_valid, res_ov_valid, res_ov, mw_valid;
  logic [7:0]  mw_mask;
  logic [31:0] cr_out;

  logic [31:0] model;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crf_cmp_unit u_crf_cmp_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_field(cmp_field),
    .cmp_signed(cmp_signed), .cmp_use_imm(cmp_use_imm), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_imm(cmp_imm), .so_in(so_in), .res_valid(res_valid), .res_value(res_value),
    .res_ov_valid(res_ov_valid), .res_ov(res_ov), .mw_valid(mw_valid), .mw_mask(mw_mask),
    .mw_data(mw_data), .cr_out(cr_out)
  );

  function automatic longint as_signed(input logic [31:0] v);
    return v[31] ? longint'(v) - 64'sd4294967296 : longint'(v);
  endfunction

  function automatic logic [3:0] order(input longint x, input longint y, input logic so);
    if (x < y) return {3'b100, so};
    if (x > y) return {3'b010, so};
    return {3'b001, so};
  endfunction

  function automatic logic [31:0] next_model(input logic [31:0] cur);
    logic [31:0] r;
    longint x, y;
    r = cur;
    if (cmp_valid) begin
      if (cmp_signed) begin
        x = as_signed(cmp_a);
        y = cmp_use_imm ? (cmp_imm[15] ? longint'(cmp_imm) - 65536 : longint'(cmp_imm))
                        : as_signed(cmp_b);
      end else begin
        x = longint'(cmp_a);
        y = cmp_use_imm ? longint'(cmp_imm) : longint'(cmp_b);
      end
      r[31 - 4*cmp_field -: 4] = order(x, y, so_in);
    end else if (res_valid) begin
      r[31:28] = order(as_signed(res_value), 0, so_in || (res_ov_valid && res_ov));
    end else if (mw_valid) begin
      for (int f = 0; f < 8; f++)
        if (mw_mask[7-f]) r[31-4*f -: 4] = mw_data[31-4*f -: 4];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_run++;
    if (cr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: cr_out=%08h expected=%08h", tag, cr_out, exp);
    end
  endtask

  task automatic idle_inputs();
    cmp_valid = 0; res_valid = 0; mw_valid = 0;
  endtask

  // Called just after a falling edge with inputs set; checks one cycle later.
  task automatic tick(input string tag);
    model = next_model(model);
    @(negedge clk);
    check(tag, model);
    idle_inputs();
  endtask

  task automatic do_cmp(input string tag, input logic [2:0] f, input logic sg, input logic ui,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                        input logic so);
    cmp_valid = 1; cmp_field = f; cmp_signed = sg; cmp_use_imm = ui;
    cmp_a = a; cmp_b = b; cmp_imm = im; so_in = so;
    tick(tag);
  endtask

  task automatic do_res(input string tag, input logic [31:0] v, input logic ovv,
                        input logic ov, input logic so);
    res_valid = 1; res_value = v; res_ov_valid = ovv; res_ov = ov; so_in = so;
    tick(tag);
  endtask

  task automatic do_mw(input string tag, input logic [7:0] m, input logic [31:0] d);
    mw_valid = 1; mw_mask = m; mw_data = d;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs();
    cmp_field = 0; cmp_signed = 0; cmp_use_imm = 0; cmp_a = 0; cmp_b = 0; cmp_imm = 0;
    so_in = 0; res_value = 0; res_ov_valid = 0; res_ov = 0; mw_mask = 0; mw_data = 0;
    model = 32'h0;
    // R1: reset even with a request pending
    mw_valid = 1; mw_mask = 8'hFF; mw_data = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0);
    idle_inputs();
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 32'h0);

    // R3 signed: -1 < 1 -> lt in field 3 (bits 19:16 = 1000)
    do_cmp("R3 signed lt", 3, 1, 0, 32'hFFFFFFFF, 32'h1, 0, 0);
    check("R2 field3 position", 32'h0008_0000);
    // R4 unsigned: same operands -> gt
    do_cmp("R4 unsigned gt", 3, 0, 0, 32'hFFFFFFFF, 32'h1, 0, 0);
    do_cmp("R3 signed eq so", 7, 1, 0, 32'h80000000, 32'h80000000, 0, 1);
    do_cmp("R4 unsigned lt", 0, 0, 0, 32'h7FFFFFFF, 32'h80000000, 0, 0);
    // R5 immediates
    do_cmp("R5 sign ext eq", 1, 1, 1, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 0);
    do_cmp("R5 zero ext lt", 2, 0, 1, 32'h0000FFFE, 32'hFFFFFFFF, 16'hFFFF, 1);
    do_cmp("R5 cmp_b ignored", 4, 1, 1, 32'h5, 32'h5, 16'h0005, 0);
    // R6 so copied, other fields held
    do_cmp("R6 so copy", 5, 1, 0, 32'h10, 32'h20, 0, 1);
    // R7 result update
    do_res("R7 neg result", 32'h80000000, 0, 0, 0);
    do_res("R7 zero result with ov", 32'h0, 1, 1, 0);
    do_res("R7 ov not valid", 32'h7, 0, 1, 0);
    do_res("R7 so already set", 32'hFFFFFFF0, 1, 0, 1);
    // R8 masked writes
    do_mw("R8 mask 0x80 field0", 8'h80, 32'hA5A5A5A5);
    do_mw("R8 mask none", 8'h00, 32'h12345678);
    do_mw("R8 mask all", 8'hFF, 32'h0123_4567);
    check("R8 whole value", 32'h0123_4567);
    do_mw("R8 mask 0x05", 8'h05, 32'hFFFF_FFFF);
    // R9 priority
    mw_valid = 1; mw_mask = 8'hFF; mw_data = 32'h0;
    res_valid = 1; res_value = 32'h1; res_ov_valid = 0; res_ov = 0;
    do_cmp("R9 compare wins", 6, 0, 0, 32'h3, 32'h3, 0, 0);
    mw_valid = 1; mw_mask = 8'hFF; mw_data = 32'h0;
    do_res("R9 result beats masked", 32'h1, 0, 0, 0);
    // R10 idle hold
    @(negedge clk);
    check("R10 idle hold", model);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = $urandom;
      cmp_valid = ($urandom % 3) == 0;
      res_valid = ($urandom % 3) == 0;
      mw_valid  = ($urandom % 3) == 0;
      cmp_field = 3'($urandom); cmp_signed = 1'($urandom); cmp_use_imm = 1'($urandom);
      cmp_a = a; cmp_b = ($urandom % 4 == 0) ? a : $urandom;
      cmp_imm = ($urandom % 4 == 0) ? a[15:0] : 16'($urandom);
      so_in = 1'($urandom); res_value = ($urandom % 5 == 0) ? 32'h0 : $urandom;
      res_ov_valid = 1'($urandom); res_ov = 1'($urandom);
      mw_mask = 8'($urandom); mw_data = $urandom;
      tick("R9 R10 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule